// File: doc/BRIEF.md
# Shift Unit with Condition Flags

This block shifts an 8-, 16- or 32-bit operand left or right and produces the condition flags that a general-purpose integer pipeline expects from such a shift. It offers three operations: a logical left shift, a logical right shift that fills with zeros, and an arithmetic right shift that fills with copies of the sign. The carry, overflow, auxiliary, zero, sign and parity flags follow the long-standing rules of that instruction family, including their odd corner cases.

The unit takes one request per clock. A request is marked by `in_valid` and carries the opcode, the operand size, the operand, a raw count and the flags as they stand before the shift. The result and the new flags are registered and appear one cycle later, marked by `out_valid`. When no request is presented, the outputs hold their last values. The count is always reduced to its low five bits before use, whatever the operand size. A reduced count of zero leaves the operand and all the flags as they were.

Top module: `shift_flag_unit`

## Requirements
- R1: Only bits [4:0] of `count` are used, for every operand size; the higher count bits have no effect.
- R2: If the masked count is zero, or the opcode is 2'b11 (no operation), `result` is the operand truncated to the selected size and `flags_out` equals `flags_in`.
- R3: Opcode 2'b00 shifts left and fills with zeros. CF is the last bit shifted out of the sized operand, and it is 0 when the count exceeds the operand width. An 8-bit shift by 16 or 24 yields zero like any count of 8 or more.
- R4: Opcode 2'b01 shifts right and fills with zeros. CF is the last bit shifted out, and it is 0 when the count exceeds the width. A 32-bit shift by 31 yields only the former top bit (0 or 1).
- R5: Opcode 2'b10 shifts right and fills every vacated bit with the original sign bit, which is itself kept. CF is the last bit shifted out, and it equals the sign bit when the count is at least the width.
- R6: For a non-zero masked count, OF is MSB(result) XOR CF for the left shift, the original operand MSB for the logical right shift, and 0 for the arithmetic right shift. The same rule holds for counts above the width.
- R7: For a non-zero masked count, AF is set to 1 by all three shifts.
- R8: For a non-zero masked count, ZF is 1 when the sized result is zero, SF is the result bit at the top of the selected size, and PF is 1 when bits [7:0] of the result hold an even number of ones. The flag vector layout is {OF, SF, ZF, AF, PF, CF}, with CF at bit 0 and OF at bit 5.
- R9: `out_valid` rises one clock after a cycle with `in_valid` high and carries the result of that request. While `in_valid` is low, `result` and `flags_out` hold their values.
- R10: While `rst_n` is low, `out_valid`, `result` and `flags_out` are all zero.
- R11: The size code 2'b00 selects 8 bits, 2'b01 selects 16 bits, and 2'b10 or 2'b11 selects 32 bits. Result bits above the selected size read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A request is presented this cycle |
| op | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 no operation |
| size | input | 2 | Operand size code |
| operand | input | 32 | Value to shift; bits above the size are ignored |
| count | input | 8 | Raw shift count; only bits [4:0] are used |
| flags_in | input | 6 | Flags before the shift, {OF,SF,ZF,AF,PF,CF} |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| result | output | 32 | Shifted value, zero above the selected size |
| flags_out | output | 6 | Updated flags, {OF,SF,ZF,AF,PF,CF} |

## Verification
The datapath has no state apart from the output register, so a wrong internal decision shows at the ports on the cycle right after the faulty request. It can show as a wrong lane mask, a carry taken from the wrong position, or the wrong fill for the arithmetic shift. Most of these faults only show in the corners: counts equal to or above the operand width, an 8-bit shift by 16 or 24, a raw count whose low five bits are zero, and a negative operand that reaches the arithmetic shift. The stimulus therefore aims at those corners before it moves on to a broad random sweep.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  parameter int unsigned DATA_W  = 32;
  parameter int unsigned CNT_W   = 5;
  parameter int unsigned CNT_IN_W = 8;
  parameter int unsigned FLAG_W  = 6;

  localparam int unsigned EXT_W  = 2 * DATA_W;
  localparam int unsigned IDX_W  = $clog2(EXT_W);
  localparam int unsigned MSB_W  = $clog2(DATA_W);
  localparam int unsigned NLANE  = 3;

  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_SAR = 2'b10,
    OP_NOP = 2'b11
  } sfu_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_WORD2 = 2'b11
  } sfu_size_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zer;
    logic aux;
    logic par;
    logic cry;
  } sfu_flags_t;

endpackage

// File: rtl/sfu_size_decode.sv
module sfu_size_decode
  import sfu_pkg::*;
(
  input  sfu_size_e                size_i,
  output logic [DATA_W-1:0]        wmask_o,
  output logic [IDX_W-1:0]         lw_o,
  output logic [MSB_W-1:0]         msb_o
);

  logic [DATA_W-1:0] lane_mask [NLANE];
  logic [IDX_W-1:0]  lane_w    [NLANE];
  logic [1:0]        sel;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int unsigned LW = 8 << g;
    localparam logic [EXT_W-1:0] ONE = 1;
    assign lane_mask[g] = DATA_W'((ONE << LW) - ONE);
    assign lane_w[g]    = IDX_W'(LW);
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: sel = 2'd0;
      SZ_HALF: sel = 2'd1;
      default: sel = 2'd2;
    endcase
  end

  always_comb begin
    wmask_o = lane_mask[sel];
    lw_o    = lane_w[sel];
    msb_o   = MSB_W'(lane_w[sel] - IDX_W'(1));
  end

endmodule

// File: rtl/sfu_shifter.sv
module sfu_shifter
  import sfu_pkg::*;
(
  input  sfu_op_e              op_i,
  input  logic [DATA_W-1:0]    opnd_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [DATA_W-1:0]    wmask_i,
  input  logic [IDX_W-1:0]     lw_i,
  input  logic [MSB_W-1:0]     msb_i,
  output logic [DATA_W-1:0]    res_o,
  output logic                 cry_o
);

  logic [EXT_W-1:0]  ext;
  logic [EXT_W-1:0]  left;
  logic [DATA_W-1:0] right;
  logic [IDX_W-1:0]  ridx;
  logic              sign;

  always_comb begin
    sign = opnd_i[msb_i];
    ext  = {{DATA_W{1'b0}}, opnd_i};
    if (op_i == OP_SAR && sign) begin
      ext = ext | ~{{DATA_W{1'b0}}, wmask_i};
    end
  end

  always_comb begin
    left  = {{DATA_W{1'b0}}, opnd_i} << cnt_i;
    right = DATA_W'(ext >> cnt_i);
    ridx  = IDX_W'(cnt_i) - IDX_W'(1);
  end

  always_comb begin
    if (op_i == OP_SHL) begin
      res_o = left[DATA_W-1:0] & wmask_i;
      cry_o = left[lw_i];
    end else begin
      res_o = right & wmask_i;
      cry_o = ext[ridx];
    end
  end

endmodule

// File: rtl/sfu_flag_gen.sv
module sfu_flag_gen
  import sfu_pkg::*;
(
  input  sfu_op_e              op_i,
  input  logic                 pass_i,
  input  logic [DATA_W-1:0]    res_i,
  input  logic                 cry_i,
  input  logic                 src_msb_i,
  input  logic [MSB_W-1:0]     msb_i,
  input  sfu_flags_t           flags_i,
  output sfu_flags_t           flags_o
);

  logic res_msb;

  always_comb begin
    res_msb = res_i[msb_i];
    flags_o = flags_i;
    if (!pass_i) begin
      flags_o.cry = cry_i;
      flags_o.aux = 1'b1;
      flags_o.zer = (res_i == '0);
      flags_o.sgn = res_msb;
      flags_o.par = ~^res_i[7:0];
      unique case (op_i)
        OP_SHL:  flags_o.ovf = res_msb ^ cry_i;
        OP_SHR:  flags_o.ovf = src_msb_i;
        default: flags_o.ovf = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import sfu_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [1:0]            op,
  input  logic [1:0]            size,
  input  logic [DATA_W-1:0]     operand,
  input  logic [CNT_IN_W-1:0]   count,
  input  logic [FLAG_W-1:0]     flags_in,
  output logic                  out_valid,
  output logic [DATA_W-1:0]     result,
  output logic [FLAG_W-1:0]     flags_out
);

  sfu_op_e           op_e;
  sfu_size_e         size_e;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] wmask;
  logic [IDX_W-1:0]  lw;
  logic [MSB_W-1:0]  msb;
  logic [DATA_W-1:0] opnd_sz;
  logic [DATA_W-1:0] sh_res;
  logic              sh_cry;
  logic              pass;
  sfu_flags_t        fl_in;
  sfu_flags_t        fl_new;

  logic              valid_d, valid_q;
  logic [DATA_W-1:0] res_d,   res_q;
  sfu_flags_t        flg_d,   flg_q;

  always_comb begin
    op_e    = sfu_op_e'(op);
    size_e  = sfu_size_e'(size);
    cnt     = count[CNT_W-1:0];
    fl_in   = sfu_flags_t'(flags_in);
    opnd_sz = operand & wmask;
    pass    = (cnt == '0) || (op_e == OP_NOP);
  end

  sfu_size_decode u_size (
    .size_i  (size_e),
    .wmask_o (wmask),
    .lw_o    (lw),
    .msb_o   (msb)
  );

  sfu_shifter u_shift (
    .op_i    (op_e),
    .opnd_i  (opnd_sz),
    .cnt_i   (cnt),
    .wmask_i (wmask),
    .lw_i    (lw),
    .msb_i   (msb),
    .res_o   (sh_res),
    .cry_o   (sh_cry)
  );

  sfu_flag_gen u_flags (
    .op_i      (op_e),
    .pass_i    (pass),
    .res_i     (sh_res),
    .cry_i     (sh_cry),
    .src_msb_i (opnd_sz[msb]),
    .msb_i     (msb),
    .flags_i   (fl_in),
    .flags_o   (fl_new)
  );

  // next-state
  always_comb begin
    valid_d = in_valid;
    res_d   = res_q;
    flg_d   = flg_q;
    if (in_valid) begin
      res_d = pass ? opnd_sz : sh_res;
      flg_d = fl_new;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
      flg_q   <= flg_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = res_q;
  assign flags_out = flg_q;

endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
  import sfu_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [1:0]           op,
  input logic [1:0]           size,
  input logic [DATA_W-1:0]    operand,
  input logic [CNT_IN_W-1:0]  count,
  input logic [FLAG_W-1:0]    flags_in,
  input logic                 out_valid,
  input logic [DATA_W-1:0]    result,
  input logic [FLAG_W-1:0]    flags_out
);

  logic active;
  assign active = in_valid && (count[4:0] != 5'd0) && (op != 2'b11);

  // R9: valid follows the request by one cycle
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid));

  // R9: outputs hold when idle
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags_out)));

  // R2: zero masked count keeps flags
  p_zero_cnt_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && count[4:0] == 5'd0) |=> flags_out == $past(flags_in));

  // R2: 32-bit pass-through keeps the value
  p_pass_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size[1] && (count[4:0] == 5'd0 || op == 2'b11)) |=> result == $past(operand));

  // R7: auxiliary flag forced on
  p_aux_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> flags_out[2]);

  // R6: arithmetic right shift clears overflow
  p_sar_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && op == 2'b10) |=> !flags_out[5]);

  // R8: zero flag agrees with the result
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> flags_out[3] == (result == '0));

  // R4: 32-bit logical right by 31 leaves at most bit 0
  p_shr31_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 2'b01 && size[1] && count[4:0] == 5'd31) |=> result[DATA_W-1:1] == '0);

endmodule

bind shift_flag_unit sfu_checker u_sfu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op        (op),
  .size      (size),
  .operand   (operand),
  .count     (count),
  .flags_in  (flags_in),
  .out_valid (out_valid),
  .result    (result),
  .flags_out (flags_out)
);

// File: tb/shift_flag_unit_bench.sv
module shift_flag_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  op;
  logic [1:0]  size;
  logic [31:0] operand;
  logic [7:0]  count;
  logic [5:0]  flags_in;
  logic        out_valid;
  logic [31:0] result;
  logic [5:0]  flags_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  typedef struct {
    logic        v;
    logic [31:0] r;
    logic [5:0]  f;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [31:0] held_r = '0;
  logic [5:0]  held_f = '0;

  shift_flag_unit u_shift_flag_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .size      (size),
    .operand   (operand),
    .count     (count),
    .flags_in  (flags_in),
    .out_valid (out_valid),
    .result    (result),
    .flags_out (flags_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural model: one bit per step
  function automatic void ref_model(input logic [1:0] o, input logic [1:0] s,
                                    input logic [31:0] x, input logic [7:0] c_raw,
                                    input logic [5:0] fin,
                                    output logic [31:0] r, output logic [5:0] f);
    int w;
    int c;
    logic [31:0] m;
    logic [31:0] v;
    logic sgn0;
    logic cf;
    logic of;
    w = (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    v = x & m;
    c = int'(c_raw) % 32;
    if (c == 0 || o == 2'b11) begin
      r = v;
      f = fin;
      return;
    end
    sgn0 = v[w-1];
    cf   = 1'b0;
    for (int i = 0; i < c; i++) begin
      if (o == 2'b00) begin
        cf = v[w-1];
        v  = (v << 1) & m;
      end else if (o == 2'b01) begin
        cf = v[0];
        v  = v >> 1;
      end else begin
        cf = v[0];
        v  = (v >> 1) | ({31'd0, sgn0} << (w - 1));
      end
    end
    if (o == 2'b00)      of = v[w-1] ^ cf;
    else if (o == 2'b01) of = sgn0;
    else                 of = 1'b0;
    r = v;
    f = {of, v[w-1], (v == 32'd0), 1'b1, ~^v[7:0], cf};
  endfunction

  task automatic apply(input bit v, input logic [1:0] o, input logic [1:0] s,
                       input logic [31:0] x, input logic [7:0] c,
                       input logic [5:0] fin, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = v;
    op       = o;
    size     = s;
    operand  = x;
    count    = c;
    flags_in = fin;
    if (v) begin
      ref_model(o, s, x, c, fin, held_r, held_f);
    end
    e.v   = v;
    e.r   = held_r;
    e.f   = held_f;
    e.tag = tag;
    expq.push_back(e);
  endtask

  always @(posedge clk) begin
    if (expq.size() > 0) begin
      #1;
      begin
        exp_t e;
        e = expq.pop_front();
        checks++;
        if (out_valid !== e.v || result !== e.r || flags_out !== e.f) begin
          fails++;
          $display("FAIL %s: got v=%0b r=%08h f=%06b, expected v=%0b r=%08h f=%06b",
                   e.tag, out_valid, result, flags_out, e.v, e.r, e.f);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    op       = 2'b00;
    size     = 2'b00;
    operand  = '0;
    count    = '0;
    flags_in = '0;
    #9;
    // R10: reset state
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || flags_out !== '0) begin
      fails++;
      $display("FAIL R10: got v=%0b r=%08h f=%06b, expected all zero",
               out_valid, result, flags_out);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R3: left shift corners
    apply(1, 2'b00, 2'b00, 32'h0000_0040, 8'h10, 6'b000000, "R3");
    apply(1, 2'b00, 2'b00, 32'h0000_0040, 8'h18, 6'b111111, "R3");
    apply(1, 2'b00, 2'b00, 32'h0000_0081, 8'd1,  6'b000000, "R3");
    apply(1, 2'b00, 2'b01, 32'h0000_8001, 8'd16, 6'b000000, "R3");
    apply(1, 2'b00, 2'b00, 32'h0000_00FF, 8'd8,  6'b000000, "R3");
    apply(1, 2'b00, 2'b00, 32'h0000_00FF, 8'd9,  6'b000000, "R3");
    // R1: high count bits ignored
    apply(1, 2'b00, 2'b10, 32'h4000_0001, 8'h21, 6'b000000, "R1");
    apply(1, 2'b01, 2'b00, 32'h0000_0080, 8'hE7, 6'b000000, "R1");
    // R4: logical right
    apply(1, 2'b01, 2'b10, 32'h8000_0000, 8'd31, 6'b000000, "R4");
    apply(1, 2'b01, 2'b10, 32'h7FFF_FFFF, 8'd31, 6'b000000, "R4");
    apply(1, 2'b01, 2'b00, 32'hFFFF_FF80, 8'd20, 6'b000000, "R4");
    // R5: arithmetic right
    apply(1, 2'b10, 2'b00, 32'h0000_0080, 8'd3,  6'b000000, "R5");
    apply(1, 2'b10, 2'b00, 32'h0000_0080, 8'd20, 6'b000000, "R5");
    apply(1, 2'b10, 2'b01, 32'h0000_7000, 8'd31, 6'b111111, "R5");
    apply(1, 2'b10, 2'b10, 32'h8000_0001, 8'd1,  6'b000000, "R5");
    apply(1, 2'b10, 2'b11, 32'hF000_0000, 8'd31, 6'b000000, "R5");
    // R6 / R7: flag rules above width
    apply(1, 2'b00, 2'b00, 32'h0000_0001, 8'd7,  6'b000000, "R6");
    apply(1, 2'b01, 2'b01, 32'h0000_8000, 8'd30, 6'b000000, "R6");
    apply(1, 2'b10, 2'b01, 32'h0000_0001, 8'd1,  6'b000000, "R7");
    // R8: parity on low byte only, sign from size
    apply(1, 2'b01, 2'b01, 32'h0000_0700, 8'd1,  6'b000000, "R8");
    apply(1, 2'b00, 2'b01, 32'h0000_4003, 8'd1,  6'b000000, "R8");
    // R2: zero masked count and no-op
    apply(1, 2'b00, 2'b00, 32'h1234_5678, 8'h20, 6'b101010, "R2");
    apply(1, 2'b11, 2'b01, 32'hABCD_EF01, 8'd5,  6'b010101, "R2");
    // R11: size codes, upper bits cleared
    apply(1, 2'b01, 2'b11, 32'hDEAD_BEEF, 8'd4,  6'b000000, "R11");
    apply(1, 2'b00, 2'b01, 32'hDEAD_BEEF, 8'd4,  6'b000000, "R11");
    // R9: idle cycles hold outputs
    apply(0, 2'b10, 2'b10, 32'hFFFF_FFFF, 8'd3,  6'b111111, "R9");
    apply(0, 2'b00, 2'b00, 32'h0000_0000, 8'd1,  6'b000000, "R9");
    apply(1, 2'b10, 2'b10, 32'h8000_0000, 8'd4,  6'b000000, "R9");

    // R8: random sweep with idle gaps
    for (int i = 0; i < 3000; i++) begin
      apply(($urandom % 5) != 0, 2'($urandom), 2'($urandom), $urandom,
            8'($urandom), 6'($urandom), "R8");
    end
    apply(0, 2'b00, 2'b00, 32'd0, 8'd0, 6'd0, "R9");

    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule